// File: doc/BRIEF.md
# Serial EEPROM Target

This block answers on a two-wire serial bus as a small byte-addressed non-volatile memory would. It resamples the clock and data lines in the system clock domain, recognises START, repeated START and STOP conditions, and decodes a device-select byte. That byte holds a fixed type code, three strap bits compared with a configuration input, and a read/write flag. The block takes a two-byte word address and supports single-byte writes, page writes of up to one page, reads from the current address, random reads and sequential reads. It pulls the data line low through an open-drain enable and never drives it high.

Written bytes are gathered in a one-page buffer and copied into storage only when the master closes the transfer with STOP. A timed internal write cycle follows. During that cycle the block gives no acknowledge and ignores the bus. For writes, the address wraps at the page boundary. For reads, it wraps at the end of the whole array.

Top module: `eeprom_target`

## Requirements
- R1: After reset the open-drain enable `sda_oe_o` is 0, so the block leaves the data line released.
- R2: The block acknowledges (drives the ninth-bit data low) a device-select byte only when bits [7:4] equal 4'b1010 and bits [3:1] equal `dev_strap_i`. Bit 0 selects the access: 0 = write, 1 = read. Any other select byte gets no acknowledge.
- R3: In a write, the select byte is followed by the high and then the low word-address byte, and each is acknowledged. The internal address is the low ADDR_W bits of {high, low}, so high-byte bits above the array size have no effect.
- R4: A write of one data byte closed by STOP stores that byte at the word address. A later read returns it.
- R5: During a page write, each data byte advances only the low PAGE_W bits of the address. Passing the last byte of a page wraps to the first byte of the same page, and the upper address bits stay fixed.
- R6: If more than 2**PAGE_W data bytes are sent, the later bytes overwrite the earlier bytes at the same page offsets.
- R7: After a STOP that closes a write with at least one data byte, the block gives no acknowledge to any access for WR_CYCLES clock cycles. Afterwards it acknowledges again.
- R8: A START that arrives before STOP discards the buffered write data. No storage byte changes, and no busy period begins.
- R9: A random read returns the byte at the word address. A random read is a select byte with bit 0 = 0, two address bytes, a repeated START, and a select byte with bit 0 = 1.
- R10: During reads the address advances by one after every byte and wraps from the last byte of the array to address 0. A read that starts with the select byte continues from the current address.
- R11: When the master answers a read byte with no acknowledge (ninth bit high), the block stops driving and leaves the data line released until the next START.
- R12: The block changes its data-line drive only while the clock line is low, and it samples received bits on clock rising edges.
- R13: After a write, the current address is the byte after the last one written, taken within the same page.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | Bus clock line as seen at the pad |
| sda_i | input | 1 | Bus data line as seen at the pad |
| dev_strap_i | input | 3 | Strap value compared with select-byte bits [3:1] |
| sda_oe_o | output | 1 | Open-drain enable: 1 pulls the data line low |

## Verification
Two functions can meet on a single clock edge. The first is the read address counter stepping past the top of the array while the next byte is being loaded. The second is a START arriving while a filled page buffer is still waiting for its STOP. The bench reaches the first by writing the last two array bytes and the first two, then reading four bytes in sequence from the next-to-last address; it expects the pair from the array top and then the pair from address 0. It reaches the second by sending a data byte, then a repeated START and a random read of the same address. That read must return the byte stored earlier, and an acknowledge that follows at once shows that no write cycle began.

// File: rtl/eeprom_pkg.sv
package eeprom_pkg;
    // Bus engine phase
    typedef enum logic [2:0] {
        S_IDLE,   // waiting for START
        S_RX,     // shifting in a byte
        S_ACKW,   // byte done, wait for SCL low to pull SDA
        S_ACK,    // holding SDA low for the ninth clock
        S_TX,     // shifting out a read byte
        S_RACK    // sampling the master's answer
    } phase_e;

    // Meaning of the byte being received
    typedef enum logic [1:0] {
        K_DEV,
        K_AHI,
        K_ALO,
        K_WD
    } kind_e;

    localparam logic [3:0] DEV_TYPE = 4'b1010;
endpackage

// File: rtl/eeprom_line_sync.sv
module eeprom_line_sync (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_i,
    input  logic sda_i,
    output logic scl_o,
    output logic sda_o,
    output logic rise_o,
    output logic fall_o,
    output logic start_o,
    output logic stop_o
);
    typedef struct packed {
        logic [1:0] scl_sr;
        logic [1:0] sda_sr;
        logic       scl_p;
        logic       sda_p;
    } sync_t;

    sync_t sync_q, sync_d;

    always_comb begin
        sync_d        = sync_q;
        sync_d.scl_sr = {sync_q.scl_sr[0], scl_i};
        sync_d.sda_sr = {sync_q.sda_sr[0], sda_i};
        sync_d.scl_p  = sync_q.scl_sr[1];
        sync_d.sda_p  = sync_q.sda_sr[1];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sync_q <= '1;
        else        sync_q <= sync_d;
    end

    assign scl_o   = sync_q.scl_sr[1];
    assign sda_o   = sync_q.sda_sr[1];
    assign rise_o  = sync_q.scl_sr[1] & ~sync_q.scl_p;
    assign fall_o  = ~sync_q.scl_sr[1] & sync_q.scl_p;
    assign start_o = sync_q.scl_sr[1] & sync_q.scl_p & sync_q.sda_p & ~sync_q.sda_sr[1];
    assign stop_o  = sync_q.scl_sr[1] & sync_q.scl_p & ~sync_q.sda_p & sync_q.sda_sr[1];
endmodule

// File: rtl/eeprom_wr_timer.sv
module eeprom_wr_timer #(
    parameter int WR_CYCLES = 500_000,
    parameter int CW        = $clog2(WR_CYCLES + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          go_i,
    output logic          busy_o,
    output logic [CW-1:0] elapsed_o
);
    typedef struct packed {
        logic          busy;
        logic [CW-1:0] cnt;
    } tmr_t;

    tmr_t tmr_q, tmr_d;

    always_comb begin
        tmr_d = tmr_q;
        if (go_i) begin
            tmr_d.busy = 1'b1;
            tmr_d.cnt  = '0;
        end else if (tmr_q.busy) begin
            if (tmr_q.cnt == CW'(WR_CYCLES - 1)) begin
                tmr_d.busy = 1'b0;
                tmr_d.cnt  = '0;
            end else begin
                tmr_d.cnt = tmr_q.cnt + 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) tmr_q <= '0;
        else        tmr_q <= tmr_d;
    end

    assign busy_o    = tmr_q.busy;
    assign elapsed_o = tmr_q.cnt;

    // R7: the window never runs past its length
    a_r7_timer_bound: assert property (@(posedge clk) disable iff (!rst_n)
        busy_o |-> (elapsed_o < CW'(WR_CYCLES)));
    // R7: a new write cycle is only requested while idle
    a_r7_go_when_idle: assert property (@(posedge clk) disable iff (!rst_n)
        go_i |-> !busy_o);
endmodule

// File: rtl/eeprom_store.sv
module eeprom_store #(
    parameter int AW = 11
) (
    input  logic          clk,
    input  logic          we_i,
    input  logic [AW-1:0] waddr_i,
    input  logic [7:0]    wdata_i,
    input  logic [AW-1:0] raddr_i,
    output logic [7:0]    rdata_o
);
    localparam int DEPTH = 1 << AW;

    logic [7:0] mem_q [DEPTH];

    always_ff @(posedge clk) begin
        if (we_i) mem_q[waddr_i] <= wdata_i;
    end

    assign rdata_o = mem_q[raddr_i];
endmodule

// File: rtl/eeprom_bus_ctrl.sv
module eeprom_bus_ctrl
    import eeprom_pkg::*;
#(
    parameter int AW = 11,
    parameter int PW = 5,
    parameter int CW = 19
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          scl_i,
    input  logic          sda_i,
    input  logic          rise_i,
    input  logic          fall_i,
    input  logic          start_i,
    input  logic          stop_i,
    input  logic [2:0]    strap_i,
    input  logic          busy_i,
    input  logic [CW-1:0] elapsed_i,
    input  logic [7:0]    rd_data_i,
    output logic [AW-1:0] rd_addr_o,
    output logic          wr_en_o,
    output logic [AW-1:0] wr_addr_o,
    output logic [7:0]    wr_data_o,
    output logic          go_busy_o,
    output logic          sda_oe_o
);
    localparam int PB = 1 << PW;

    typedef struct packed {
        phase_e             st;
        kind_e              kind;
        logic [3:0]         cnt;
        logic [7:0]         sh;
        logic               rd;
        logic               more;
        logic [7:0]         ahi;
        logic [AW-1:0]      addr;
        logic               oe;
        logic [PB-1:0]      valid;
        logic [PB-1:0][7:0] pbuf;
    } ctl_t;

    ctl_t ctl_q, ctl_d;

    logic [7:0]    byte_v;
    logic [PW-1:0] off_v;
    logic [PW-1:0] cidx;
    logic          commit_slot;

    assign byte_v      = {ctl_q.sh[6:0], sda_i};
    assign off_v       = ctl_q.addr[PW-1:0];
    assign cidx        = elapsed_i[PW-1:0];
    assign commit_slot = busy_i && (elapsed_i < CW'(PB));

    always_comb begin
        ctl_d = ctl_q;
        if (busy_i) begin
            // internal write cycle: bus is ignored
            ctl_d.st = S_IDLE;
            ctl_d.oe = 1'b0;
            if (elapsed_i == CW'(PB)) ctl_d.valid = '0;
        end else if (start_i) begin
            ctl_d.st    = S_RX;
            ctl_d.kind  = K_DEV;
            ctl_d.cnt   = '0;
            ctl_d.oe    = 1'b0;
            ctl_d.valid = '0;
        end else if (stop_i) begin
            ctl_d.st = S_IDLE;
            ctl_d.oe = 1'b0;
        end else begin
            unique case (ctl_q.st)
                S_RX: begin
                    if (rise_i) begin
                        ctl_d.sh  = byte_v;
                        ctl_d.cnt = ctl_q.cnt + 4'd1;
                        if (ctl_q.cnt == 4'd7) begin
                            ctl_d.st = S_ACKW;
                            unique case (ctl_q.kind)
                                K_DEV: begin
                                    ctl_d.rd = byte_v[0];
                                    if (byte_v[7:4] != DEV_TYPE || byte_v[3:1] != strap_i)
                                        ctl_d.st = S_IDLE;
                                end
                                K_AHI: ctl_d.ahi = byte_v;
                                K_ALO: begin
                                    ctl_d.addr  = AW'({ctl_q.ahi, byte_v});
                                    ctl_d.valid = '0;
                                end
                                K_WD: begin
                                    ctl_d.pbuf[off_v]       = byte_v;
                                    ctl_d.valid[off_v]      = 1'b1;
                                    ctl_d.addr[PW-1:0]      = off_v + 1'b1;
                                end
                                default: ;
                            endcase
                        end
                    end
                end
                S_ACKW: begin
                    if (fall_i) begin
                        ctl_d.oe = 1'b1;
                        ctl_d.st = S_ACK;
                    end
                end
                S_ACK: begin
                    if (fall_i) begin
                        ctl_d.oe  = 1'b0;
                        ctl_d.cnt = '0;
                        ctl_d.st  = S_RX;
                        unique case (ctl_q.kind)
                            K_DEV: begin
                                if (ctl_q.rd) begin
                                    ctl_d.sh = rd_data_i;
                                    ctl_d.oe = ~rd_data_i[7];
                                    ctl_d.st = S_TX;
                                end else begin
                                    ctl_d.kind = K_AHI;
                                end
                            end
                            K_AHI:   ctl_d.kind = K_ALO;
                            default: ctl_d.kind = K_WD;
                        endcase
                    end
                end
                S_TX: begin
                    if (rise_i) ctl_d.cnt = ctl_q.cnt + 4'd1;
                    if (fall_i) begin
                        if (ctl_q.cnt == 4'd8) begin
                            ctl_d.oe   = 1'b0;
                            ctl_d.st   = S_RACK;
                            ctl_d.addr = ctl_q.addr + 1'b1;
                        end else begin
                            ctl_d.sh = {ctl_q.sh[6:0], 1'b0};
                            ctl_d.oe = ~ctl_q.sh[6];
                        end
                    end
                end
                S_RACK: begin
                    if (rise_i) ctl_d.more = ~sda_i;
                    if (fall_i) begin
                        if (ctl_q.more) begin
                            ctl_d.sh  = rd_data_i;
                            ctl_d.oe  = ~rd_data_i[7];
                            ctl_d.cnt = '0;
                            ctl_d.st  = S_TX;
                        end else begin
                            ctl_d.st = S_IDLE;
                        end
                    end
                end
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) ctl_q <= '0;
        else        ctl_q <= ctl_d;
    end

    assign rd_addr_o = ctl_q.addr;
    assign wr_en_o   = commit_slot && ctl_q.valid[cidx];
    assign wr_addr_o = {ctl_q.addr[AW-1:PW], cidx};
    assign wr_data_o = ctl_q.pbuf[cidx];
    assign go_busy_o = stop_i && !busy_i && (|ctl_q.valid);
    assign sda_oe_o  = ctl_q.oe;

    // R12: drive is only asserted right after SCL was seen low
    a_r12_drive_scl_low: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ctl_q.oe) |-> !$past(scl_i));
    // R7: the timer's busy window silences the line
    a_r7_quiet_busy: assert property (@(posedge clk) disable iff (!rst_n)
        busy_i |=> !ctl_q.oe);
    // R10: one step of the address counter per transmitted byte
    a_r10_addr_step: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(ctl_q.st == S_TX) && ctl_q.st == S_RACK) |-> (ctl_q.addr == $past(ctl_q.addr) + 1'b1));
    // R5: a received data byte leaves the page bits untouched
    a_r5_page_fixed: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(ctl_q.st == S_RX && ctl_q.kind == K_WD) && ctl_q.st == S_ACKW)
        |-> (ctl_q.addr[AW-1:PW] == $past(ctl_q.addr[AW-1:PW])));
endmodule

// File: rtl/eeprom_target.sv
module eeprom_target #(
    parameter int ADDR_W    = 11,
    parameter int PAGE_W    = 5,
    parameter int WR_CYCLES = 500_000
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       scl_i,
    input  logic       sda_i,
    input  logic [2:0] dev_strap_i,
    output logic       sda_oe_o
);
    localparam int CW = $clog2(WR_CYCLES + 1);

    logic scl_s, sda_s, scl_rise, scl_fall, bus_start, bus_stop;
    logic busy, go_busy;
    logic [CW-1:0] elapsed;
    logic [ADDR_W-1:0] rd_addr, wr_addr;
    logic [7:0] rd_data, wr_data;
    logic mem_we;

    eeprom_line_sync u_sync (
        .clk    (clk),
        .rst_n  (rst_n),
        .scl_i  (scl_i),
        .sda_i  (sda_i),
        .scl_o  (scl_s),
        .sda_o  (sda_s),
        .rise_o (scl_rise),
        .fall_o (scl_fall),
        .start_o(bus_start),
        .stop_o (bus_stop)
    );

    eeprom_wr_timer #(.WR_CYCLES(WR_CYCLES), .CW(CW)) u_timer (
        .clk      (clk),
        .rst_n    (rst_n),
        .go_i     (go_busy),
        .busy_o   (busy),
        .elapsed_o(elapsed)
    );

    eeprom_bus_ctrl #(.AW(ADDR_W), .PW(PAGE_W), .CW(CW)) u_ctrl (
        .clk      (clk),
        .rst_n    (rst_n),
        .scl_i    (scl_s),
        .sda_i    (sda_s),
        .rise_i   (scl_rise),
        .fall_i   (scl_fall),
        .start_i  (bus_start),
        .stop_i   (bus_stop),
        .strap_i  (dev_strap_i),
        .busy_i   (busy),
        .elapsed_i(elapsed),
        .rd_data_i(rd_data),
        .rd_addr_o(rd_addr),
        .wr_en_o  (mem_we),
        .wr_addr_o(wr_addr),
        .wr_data_o(wr_data),
        .go_busy_o(go_busy),
        .sda_oe_o (sda_oe_o)
    );

    eeprom_store #(.AW(ADDR_W)) u_store (
        .clk    (clk),
        .we_i   (mem_we),
        .waddr_i(wr_addr),
        .wdata_i(wr_data),
        .raddr_i(rd_addr),
        .rdata_o(rd_data)
    );

    // R4/R8: storage changes only inside a committed write cycle
    a_r4_write_in_busy: assert property (@(posedge clk) disable iff (!rst_n)
        mem_we |-> busy);
endmodule

// File: tb/eeprom_target_tb_top.sv
module eeprom_target_tb_top;
    localparam int AW    = 11;
    localparam int DEPTH = 1 << AW;
    localparam int WRC   = 400;
    localparam logic [7:0] DEV_W = 8'hAA; // 1010 + strap 101 + write
    localparam logic [7:0] DEV_R = 8'hAB;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic scl_m = 1'b1;
    logic sda_m = 1'b1;
    logic [2:0] strap = 3'b101;
    logic sda_oe;
    wire  sda_line = sda_m & ~sda_oe;

    always #10 clk = ~clk;

    eeprom_target #(.ADDR_W(AW), .PAGE_W(5), .WR_CYCLES(WRC)) dut_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .scl_i      (scl_m),
        .sda_i      (sda_line),
        .dev_strap_i(strap),
        .sda_oe_o   (sda_oe)
    );

    int checks = 0;
    int errors = 0;
    int r12_viol = 0;
    bit finished = 0;
    logic [7:0] ref_mem [DEPTH];
    int ref_addr = 0;
    logic prev_oe = 1'b0;

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    // every-clock monitor: drive changes only while SCL low (R12)
    always @(negedge clk) begin
        if (rst_n && (sda_oe !== prev_oe) && scl_m) r12_viol++;
        prev_oe = sda_oe;
    end

    task automatic wt(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic bstart();
        if (scl_m) begin
            sda_m = 1'b1; wt(8);
        end else begin
            sda_m = 1'b1; wt(4); scl_m = 1'b1; wt(8);
        end
        sda_m = 1'b0; wt(8); scl_m = 1'b0;
    endtask

    task automatic bstop();
        wt(4); sda_m = 1'b0; wt(4); scl_m = 1'b1; wt(8); sda_m = 1'b1; wt(8);
    endtask

    task automatic bit_w(input logic b);
        wt(4); sda_m = b; wt(4); scl_m = 1'b1; wt(8); scl_m = 1'b0;
    endtask

    task automatic bit_r(output logic b);
        sda_m = 1'b1; wt(8); scl_m = 1'b1; wt(4); b = sda_line; wt(4); scl_m = 1'b0;
    endtask

    task automatic send(input logic [7:0] v, output bit ack);
        logic b;
        for (int i = 7; i >= 0; i--) bit_w(v[i]);
        bit_r(b);
        ack = ~b;
    endtask

    task automatic recv(input bit mack, output logic [7:0] v);
        logic b;
        for (int i = 7; i >= 0; i--) begin
            bit_r(b);
            v[i] = b;
        end
        bit_w(~mack);
    endtask

    task automatic send_ok(input logic [7:0] v, input string req);
        bit a;
        send(v, a);
        chk(a, req, "ack on byte", a, 1);
    endtask

    // reference model of a committed page write
    task automatic m_write(input int a, input logic [7:0] dat [$]);
        int base;
        base = a & (DEPTH - 1) & ~31;
        for (int i = 0; i < dat.size(); i++)
            ref_mem[base | ((a + i) & 31)] = dat[i];
        ref_addr = base | ((a + dat.size()) & 31);
    endtask

    task automatic wait_busy(input int n, input string req);
        int viol = 0;
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            if (sda_oe) viol++;
        end
        chk(viol == 0, req, "line driven during write cycle", viol, 0);
    endtask

    task automatic write_txn(input logic [7:0] hi, input logic [7:0] lo,
                             input logic [7:0] dat [$], input string req);
        bstart();
        send_ok(DEV_W, "R2");
        send_ok(hi, "R3");
        send_ok(lo, "R3");
        foreach (dat[i]) send_ok(dat[i], req);
        bstop();
        m_write({hi, lo}, dat);
    endtask

    task automatic read_check(input int n, input string req);
        logic [7:0] v;
        for (int i = 0; i < n; i++) begin
            recv(i != n - 1, v);
            chk(v === ref_mem[ref_addr], req, $sformatf("read byte at %0h", ref_addr),
                v, ref_mem[ref_addr]);
            ref_addr = (ref_addr + 1) % DEPTH;
        end
    endtask

    task automatic rand_read(input int a, input int n, input string req);
        bstart();
        send_ok(DEV_W, "R2");
        send_ok(8'(a >> 8), "R3");
        send_ok(8'(a), "R3");
        bstart();
        send_ok(DEV_R, "R9");
        ref_addr = a;
        read_check(n, req);
        bstop();
    endtask

    task automatic cur_read(input int n, input string req);
        bstart();
        send_ok(DEV_R, "R2");
        read_check(n, req);
        bstop();
    endtask

    initial begin
        logic [7:0] dq [$];
        bit a;
        logic b;

        wt(5);
        chk(sda_oe == 1'b0, "R1", "oe during reset", sda_oe, 0);
        rst_n = 1'b1;
        wt(10);
        chk(sda_oe == 1'b0, "R1", "oe after reset", sda_oe, 0);

        // R2: wrong strap and wrong type code are not acknowledged
        bstart(); send(8'hA4, a); bstop();
        chk(!a, "R2", "ack for wrong strap", a, 0);
        bstart(); send(8'hBA, a); bstop();
        chk(!a, "R2", "ack for wrong type", a, 0);

        // R3/R4: byte write, high byte bits above the array ignored
        dq = '{8'h5C};
        write_txn(8'hF9, 8'h23, dq, "R4");
        // R7: an access inside the write cycle gets no acknowledge
        bstart(); send(DEV_W, a); bstop();
        chk(!a, "R7", "ack while busy", a, 0);
        wait_busy(WRC, "R7");
        bstart(); send(DEV_W, a); bstop();
        chk(a, "R7", "ack after write cycle", a, 1);

        // R9: random read of the same byte through a different high byte
        bstart();
        send_ok(DEV_W, "R2"); send_ok(8'h01, "R3"); send_ok(8'h23, "R3");
        bstart();
        send_ok(DEV_R, "R9");
        ref_addr = 'h123;
        read_check(1, "R9");
        // R11: after the master NACK the line stays released
        bit_r(b);
        chk(b == 1'b1, "R11", "line after master nack", b, 1);
        bstop();

        // R5: page write crossing the page end wraps inside the page
        dq = '{8'h10, 8'h11, 8'h12, 8'h13, 8'h14};
        write_txn(8'h00, 8'h5E, dq, "R5");
        wait_busy(WRC + 20, "R7");
        rand_read('h05E, 2, "R5");
        rand_read('h040, 3, "R5");

        // R6: more than one page of data overwrites early offsets
        dq.delete();
        for (int i = 0; i < 34; i++) dq.push_back(8'(i * 7 + 1));
        write_txn(8'h00, 8'h80, dq, "R6");
        wait_busy(WRC + 20, "R7");
        // R13: current address follows the last written offset
        cur_read(1, "R13");
        rand_read('h080, 4, "R6");
        rand_read('h09F, 1, "R6");

        // R8: repeated START before STOP discards buffered data
        dq = '{8'h33};
        write_txn(8'h01, 8'h00, dq, "R4");
        wait_busy(WRC + 20, "R7");
        bstart();
        send_ok(DEV_W, "R2"); send_ok(8'h01, "R3"); send_ok(8'h00, "R3");
        send_ok(8'hEE, "R8");
        rand_read('h100, 1, "R8");
        bstart(); send(DEV_W, a); bstop();
        chk(a, "R8", "ack right after aborted write", a, 1);

        // R10: sequential read wraps from array top to 0
        dq = '{8'hA1, 8'hA2};
        write_txn(8'h07, 8'hFE, dq, "R4");
        wait_busy(WRC + 20, "R7");
        dq = '{8'hB1, 8'hB2};
        write_txn(8'h00, 8'h00, dq, "R4");
        wait_busy(WRC + 20, "R7");
        rand_read('h7FE, 4, "R10");
        rand_read('h7FF, 2, "R10");
        cur_read(1, "R10");

        chk(r12_viol == 0, "R12", "drive changes with SCL high", r12_viol, 0);
        finished = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end
endmodule